// File: doc/BRIEF.md
# Paced Conversion Cycle Controller

This block sequences repeated analog-to-digital conversion cycles. Each cycle lasts a fixed number of clock steps, by default 16. A convert strobe pulses early in the cycle. A result-latch pulse marks the last step. BUSY covers every step before the latch step.

A new cycle may begin only at a check point: the last step of a running cycle, or any clock while the machine is parked. At that point three things must all be true:
- A fresh channel address has been strobed by the host since the current cycle began.
- The pacing source is ready.
- In external mode, an external pace edge has been seen since the current cycle began.

When these hold at the end of every cycle, cycles run back to back, with BUSY dropping for exactly one clock between them. When any of them fails, the machine parks in a wait state. It leaves that state on its own as soon as the blocking condition clears.

Internal pacing uses a down-counter. The counter reloads from the pace interval input whenever a cycle starts, and pacing is ready when the counter is zero. An interval of zero therefore disables pacing. In external mode the internal counter is ignored and a rising edge on the pace input takes its place.

Top module: `conv_cycle_ctrl`

## Requirements
- R1: After synchronous reset the controller is parked: `cyc_state` is 0, `cyc_step` is 0, and `busy`, `convert_strobe` and `result_latch` are all low.
- R2: From the parked state, with pacing ready, an `addr_strobe` presented in one clock starts a cycle on the second rising edge after it. The cycle starts with `cyc_state` = 1 (running), `cyc_step` = 0 and `busy` high.
- R3: `convert_strobe` is high in step 1 of every cycle and in no other clock.
- R4: `busy` is high in steps 0 to 14 and low in step 15. `result_latch` is high only in step 15.
- R5: If no `addr_strobe` arrived after the current cycle started, the step after step 15 is the parked state (`cyc_state` = 0, `busy` low). The controller stays parked until a strobe arrives, and then restarts as in R2.
- R6: In internal mode with a pace interval of 1 to 15 loaded at cycle start, and an address strobed during the cycle, step 0 of the next cycle follows step 15 directly. Cycle starts are then 16 clocks apart.
- R7: In internal mode with an interval N greater than 15 loaded at cycle start, the next cycle's step 0 comes exactly N+1 clocks after this cycle's step 0. The controller is parked in between.
- R8: A pace interval of 0 disables internal pacing. A cycle loaded with 0 is followed back to back, 16 clocks later, when an address is pending.
- R9: When `ext_pace_mode` is 1, a cycle starts only after a rising edge on `ext_pace`. The start comes on the second rising clock edge after the edge appears. `pace_interval` has no effect, and a level held high does not start a second cycle.
- R10: `cyc_state` encodes parked as 0 and running as 1. `cyc_step` counts 0 to 15 by one per clock while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | One-clock pulse: host supplied a new channel address |
| ext_pace_mode | input | 1 | 1 selects external pacing |
| ext_pace | input | 1 | External pace signal; its rising edges pace cycles |
| pace_interval | input | 8 | Internal pace interval in clocks; 0 disables the timer |
| busy | output | 1 | Conversion in progress |
| convert_strobe | output | 1 | Start-of-conversion pulse (step 1) |
| result_latch | output | 1 | Result latch pulse (last step) |
| cyc_state | output | 2 | 0 parked, 1 running |
| cyc_step | output | 4 | Current step of the conversion cycle |

## Verification
The bench builds the block with its default parameters: a 16-step cycle, the convert strobe in step 1, and an 8-bit pace interval. With these values, intervals of 0, 15, 20 and 200 fit in one short run.

Intervals of 15 and 20 sit on either side of the point where pacing starts to lengthen the cycle, so both the back-to-back case and the N+1 period case are measured. An interval of 200 in external mode shows that the internal timer is ignored. The external-mode test holds the pace input high to confirm that a level, rather than an edge, starts nothing.

// File: rtl/conv_cycle_pkg.sv
package conv_cycle_pkg;

    // Controller state, brought out on the cyc_state port
    typedef enum logic [1:0] {
        ST_WAIT = 2'b00,
        ST_RUN  = 2'b01
    } cyc_state_e;

    // Run conditions evaluated at a check point
    typedef struct packed {
        logic addr_ok;   // fresh address strobed since last start
        logic pace_ok;   // internal timer expired or external edge seen
    } run_gate_t;

    // Per-step decoded outputs of the sequencer
    typedef struct packed {
        logic busy;
        logic conv;
        logic latch;
    } step_out_t;

    function automatic logic gate_open(input run_gate_t g);
        return g.addr_ok & g.pace_ok;
    endfunction

endpackage

// File: rtl/conv_pace_timer.sv
module conv_pace_timer #(
    parameter int PACE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PACE_W-1:0] interval,
    output logic              ready
);
    logic [PACE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= interval;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A zero count means the interval has elapsed (or pacing is disabled)
    assign ready = (cnt_q == '0);

endmodule

// File: rtl/conv_run_gate.sv
module conv_run_gate
    import conv_cycle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      addr_strobe,
    input  logic      ext_mode,
    input  logic      ext_pace,
    input  logic      timer_ready,
    input  logic      start,
    output run_gate_t gate
);
    logic addr_pend_q;
    logic ext_prev_q;
    logic ext_seen_q;
    logic ext_rise;

    assign ext_rise = ext_pace & ~ext_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_pend_q <= 1'b0;
            ext_prev_q  <= 1'b0;
            ext_seen_q  <= 1'b0;
        end else begin
            // A strobe in the start clock counts toward the next cycle
            addr_pend_q <= addr_strobe | (addr_pend_q & ~start);
            ext_prev_q  <= ext_pace;
            // Edges only collected while external pacing is selected
            ext_seen_q  <= ext_mode & (ext_rise | (ext_seen_q & ~start));
        end
    end

    always_comb begin
        gate.addr_ok = addr_pend_q;
        gate.pace_ok = ext_mode ? ext_seen_q : timer_ready;
    end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_cycle_pkg::*;
#(
    parameter int CYCLE_LEN = 16,
    parameter int CONV_STEP = 1,
    parameter int STEP_W    = $clog2(CYCLE_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  run_gate_t         gate,
    output logic              start,
    output cyc_state_e        state,
    output logic [STEP_W-1:0] step,
    output step_out_t         outs
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CYCLE_LEN - 1);
    localparam logic [STEP_W-1:0] CONV_AT   = STEP_W'(CONV_STEP);

    cyc_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic              at_check;

    assign at_check = (state_q == ST_WAIT) ||
                      (state_q == ST_RUN && step_q == LAST_STEP);
    assign start    = at_check && gate_open(gate);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            step_q  <= '0;
        end else if (start) begin
            state_q <= ST_RUN;
            step_q  <= '0;
        end else if (state_q == ST_RUN) begin
            if (step_q == LAST_STEP) begin
                state_q <= ST_WAIT;
                step_q  <= '0;
            end else begin
                step_q  <= step_q + 1'b1;
            end
        end
    end

    always_comb begin
        outs.busy  = (state_q == ST_RUN) && (step_q != LAST_STEP);
        outs.conv  = (state_q == ST_RUN) && (step_q == CONV_AT);
        outs.latch = (state_q == ST_RUN) && (step_q == LAST_STEP);
    end

    assign state = state_q;
    assign step  = step_q;

endmodule

// File: rtl/conv_cycle_ctrl.sv
module conv_cycle_ctrl
    import conv_cycle_pkg::*;
#(
    parameter int CYCLE_LEN = 16,
    parameter int CONV_STEP = 1,
    parameter int PACE_W    = 8,
    parameter int STEP_W    = $clog2(CYCLE_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic              ext_pace_mode,
    input  logic              ext_pace,
    input  logic [PACE_W-1:0] pace_interval,
    output logic              busy,
    output logic              convert_strobe,
    output logic              result_latch,
    output logic [1:0]        cyc_state,
    output logic [STEP_W-1:0] cyc_step
);
    run_gate_t  gate;
    logic       start;
    logic       timer_ready;
    cyc_state_e state;
    step_out_t  outs;

    conv_pace_timer #(.PACE_W(PACE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .interval (pace_interval),
        .ready    (timer_ready)
    );

    conv_run_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .addr_strobe (addr_strobe),
        .ext_mode    (ext_pace_mode),
        .ext_pace    (ext_pace),
        .timer_ready (timer_ready),
        .start       (start),
        .gate        (gate)
    );

    conv_sequencer #(
        .CYCLE_LEN (CYCLE_LEN),
        .CONV_STEP (CONV_STEP),
        .STEP_W    (STEP_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .gate  (gate),
        .start (start),
        .state (state),
        .step  (cyc_step),
        .outs  (outs)
    );

    assign busy           = outs.busy;
    assign convert_strobe = outs.conv;
    assign result_latch   = outs.latch;
    assign cyc_state      = state;

endmodule

// File: rtl/conv_cycle_ctrl_chk.sv
module conv_cycle_ctrl_chk #(
    parameter int CYCLE_LEN = 16,
    parameter int CONV_STEP = 1,
    parameter int STEP_W    = $clog2(CYCLE_LEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              convert_strobe,
    input logic              result_latch,
    input logic [1:0]        cyc_state,
    input logic [STEP_W-1:0] cyc_step
);
    localparam logic [1:0]        RUN_ENC = 2'b01;
    localparam logic [1:0]        WAIT_ENC = 2'b00;
    localparam logic [STEP_W-1:0] PRE_CONV = STEP_W'(CONV_STEP - 1);

    // R2
    busy_rise_at_step0_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cyc_state == RUN_ENC && cyc_step == '0));

    // R10
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_state == RUN_ENC && cyc_step != '0) |->
            ($past(cyc_state) == RUN_ENC && cyc_step == $past(cyc_step) + 1'b1));

    // R3
    conv_after_prestep_chk: assert property (@(posedge clk) disable iff (rst)
        convert_strobe |-> ($past(cyc_state) == RUN_ENC && $past(cyc_step) == PRE_CONV));

    // R4
    latch_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        result_latch |-> !busy);

    // R4
    latch_then_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        result_latch |=> (cyc_state == WAIT_ENC || cyc_step == '0));

    // R4
    busy_only_running_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cyc_state == RUN_ENC);

    // R3
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({convert_strobe, result_latch}));

endmodule

bind conv_cycle_ctrl conv_cycle_ctrl_chk #(
    .CYCLE_LEN (CYCLE_LEN),
    .CONV_STEP (CONV_STEP),
    .STEP_W    (STEP_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .convert_strobe (convert_strobe),
    .result_latch   (result_latch),
    .cyc_state      (cyc_state),
    .cyc_step       (cyc_step)
);

// File: tb/test_conv_cycle_ctrl.sv
`timescale 1ns/1ps
module test_conv_cycle_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_strobe = 1'b0;
    logic       ext_pace_mode = 1'b0;
    logic       ext_pace = 1'b0;
    logic [7:0] pace_interval = 8'd0;
    logic       busy, convert_strobe, result_latch;
    logic [1:0] cyc_state;
    logic [3:0] cyc_step;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    conv_cycle_ctrl i_conv_cycle_ctrl (
        .clk            (clk),
        .rst            (rst),
        .addr_strobe    (addr_strobe),
        .ext_pace_mode  (ext_pace_mode),
        .ext_pace       (ext_pace),
        .pace_interval  (pace_interval),
        .busy           (busy),
        .convert_strobe (convert_strobe),
        .result_latch   (result_latch),
        .cyc_state      (cyc_state),
        .cyc_step       (cyc_step)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit at_step0();
        return cyc_state == 2'd1 && cyc_step == 4'd0;
    endfunction

    // Present one address strobe from the parked state; returns at the
    // negedge where step 0 should be visible.
    task automatic start_from_wait();
        addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        @(negedge clk);
    endtask

    // From a negedge showing step 0, strobe an address at offset addr_at
    // (0 = never) and count clocks to the next step 0 (0 = none in limit).
    task automatic run_period(input int addr_at, input int limit, output int period);
        period = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (at_step0()) begin
                period = i;
                addr_strobe = 1'b0;
                break;
            end
            addr_strobe = (i == addr_at);
        end
        addr_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk(cyc_state == 2'd0, "R1 state", cyc_state, 0);
        chk(cyc_step == 4'd0, "R1 step", cyc_step, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(!convert_strobe && !result_latch, "R1 pulses",
            {convert_strobe, result_latch}, 0);
        chk(cyc_state == 2'd0, "R10 parked encoding", cyc_state, 0);
    endtask

    task automatic t_single_cycle();
        pace_interval = 8'd0;
        start_from_wait();
        chk(at_step0(), "R2 start at step 0", {cyc_state, cyc_step}, 16);
        for (int k = 0; k < 16; k++) begin
            chk(cyc_step == 4'(k) && cyc_state == 2'd1, "R10 step count", cyc_step, k);
            chk(busy == (k != 15), "R4 busy window", busy, int'(k != 15));
            chk(convert_strobe == (k == 1), "R3 convert step", convert_strobe, int'(k == 1));
            chk(result_latch == (k == 15), "R4 latch step", result_latch, int'(k == 15));
            @(negedge clk);
        end
        chk(cyc_state == 2'd0 && !busy, "R5 park without address", cyc_state, 0);
        for (int k = 0; k < 6; k++) @(negedge clk);
        chk(cyc_state == 2'd0 && !busy, "R5 stays parked", cyc_state, 0);
        start_from_wait();
        chk(at_step0(), "R5 resume after strobe", {cyc_state, cyc_step}, 16);
    endtask

    task automatic t_internal_pacing();
        int p;
        // current cycle loaded 0; next start loads 15
        pace_interval = 8'd15;
        run_period(5, 40, p);
        chk(p == 16, "R8 interval 0 back to back", p, 16);
        run_period(5, 40, p);
        chk(p == 16, "R6 interval 15 back to back", p, 16);
        pace_interval = 8'd20;
        run_period(5, 40, p);
        chk(p == 16, "R6 interval 15 again", p, 16);
        run_period(5, 40, p);
        chk(p == 21, "R7 interval 20 period", p, 21);
        run_period(0, 40, p);
        chk(p == 0, "R5 no address stops", p, 0);
        chk(cyc_state == 2'd0, "R5 parked", cyc_state, 0);
    endtask

    task automatic t_external_pacing();
        int p;
        ext_pace_mode = 1'b1;
        pace_interval = 8'd200;
        @(negedge clk);
        addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        for (int k = 0; k < 10; k++) @(negedge clk);
        chk(cyc_state == 2'd0, "R9 no edge no start", cyc_state, 0);
        ext_pace = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(at_step0(), "R9 start after edge, timer ignored", {cyc_state, cyc_step}, 16);
        run_period(5, 40, p);
        chk(p == 0, "R9 held level does not retrigger", p, 0);
        chk(cyc_state == 2'd0, "R9 parked on level", cyc_state, 0);
        ext_pace = 1'b0;
        @(negedge clk);
        ext_pace = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(at_step0(), "R9 second edge restarts", {cyc_state, cyc_step}, 16);
        ext_pace_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_cycle();
        t_internal_pacing();
        t_external_pacing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule